// File: doc/BRIEF.md
# DMA Channel Interrupt Aggregator

This block collects interrupt causes from a bank of DMA channels and folds them onto four interrupt lines. Each channel raises two kinds of event, a descriptor-completion pulse and an error pulse. Every channel keeps a separate copy of its latched causes and its enable mask for each of the four lines. Software handling one line therefore clears and masks only its own copy. Direction follows channel parity: even channels move data out to a device and odd channels move data in. A transmit summary word and a receive summary word, each with one bit per channel pair, show which channels are pending on a given line. A global word of miscellaneous event flags is kept per line alongside them.

The same word-addressed register port also carries the run control. A write to a transmit or receive start register sets the run flag of every channel whose pair index has a 1 in the written value. The matching stop register clears those flags. The channel data path sits outside this block and consumes the `chan_run` flags.

Top module: `dma_irq_agg`

## Requirements
- R1: After reset all latched causes, masks, global words and run flags are zero, `irq_o` is all low and every register address reads zero.
- R2: A pulse on `done_evt[c]` sets the completion cause (status bit 0) of channel c in all four line copies. A pulse on `err_evt[c]` sets the error cause (status bit 6). Status bits other than 0 and 6 read zero.
- R3: A write to status copy L of channel c (word address 0x10 + 8·c + L) clears the causes whose bit (0 or 6) is 1 in the written value. It clears them in that copy only; written zeros and other copies are untouched.
- R4: If a cause event arrives in the same cycle as a write that clears that cause, the cause ends up set.
- R5: A write to mask copy L of channel c (word address 0x14 + 8·c + L) stores written bits 0 and 6 as the enables for completion and error. Reads return them in those positions and zero elsewhere.
- R6: For line L, transmit summary bit n (address 0x04 + L) is 1 when channel 2n has a cause whose enable is set in copy L. Receive summary bit n (address 0x08 + L) does the same for channel 2n+1.
- R7: `irq_o[L]` is high exactly when any transmit or receive summary bit for line L, or any bit of global word L, is 1.
- R8: A `glb_evt` pulse ORs its bits into all four global words (address 0x0C + L). Writing a value with every bit set to global word L clears it. Any other value written there changes nothing.
- R9: Writing value v to transmit start (0x00) sets the run flag of channel 2n for every bit n set in v. Receive start (0x02) does this for channel 2n+1. Transmit stop (0x01) and receive stop (0x03) clear the same flags, and zero bits leave flags alone. Reading 0x00 or 0x01 returns the transmit run flags per pair, and reading 0x02 or 0x03 returns the receive ones.
- R10: Writes to unmapped addresses change no state, and reads from unmapped addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| done_evt | input | NCH | Descriptor-completion pulse per channel |
| err_evt | input | NCH | Error pulse per channel |
| glb_evt | input | GW | Global event flags, set into every line's global word |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | DW | Register write data |
| bus_rdata | output | DW | Register read data for `bus_addr`, combinational |
| chan_run | output | NCH | Run flag per channel |
| irq_o | output | 4 | Interrupt lines |

## Verification
The bench aims at cross-copy isolation. A clear or mask write that leaked into a neighbouring line copy would drop or raise the wrong `irq_o` bit. It drives a completion event in the same cycle as a clear of that cause. A design that let the clear win would lose an interrupt and show a status read of zero. It writes near-miss values such as all-ones-but-one to the global words, because a design that cleared per bit would wipe flags that should survive. It also checks that start and stop bits land on channel 2n or 2n+1 and not on channel n. A pair-indexing slip would show up as the wrong `chan_run` pattern and as wrong summary bits.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

    // Number of interrupt lines, each with its own cause/mask copy.
    localparam int NOUT = 4;

    // Positions of the two causes inside a status or mask word.
    localparam int DONE_BIT = 0;
    localparam int ERR_BIT  = 6;

    // Word address map.
    localparam int A_TXGO    = 0;
    localparam int A_TXHALT  = 1;
    localparam int A_RXGO    = 2;
    localparam int A_RXHALT  = 3;
    localparam int A_TXSUM   = 4;
    localparam int A_RXSUM   = 8;
    localparam int A_GLB     = 12;
    localparam int A_CHAN    = 16;
    localparam int CH_STRIDE = 8;

    // Compact cause pair: [1] error, [0] completion.
    typedef logic [1:0] cause_t;

endpackage

// File: rtl/irqagg_chan.sv
module irqagg_chan
    import irqagg_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_evt,
    input  logic              err_evt,
    input  logic [NOUT-1:0]   clr_sel,
    input  logic [NOUT-1:0]   msk_sel,
    input  logic [DW-1:0]     wdata,
    output cause_t [NOUT-1:0] cause,
    output cause_t [NOUT-1:0] mask,
    output logic [NOUT-1:0]   hit
);

    typedef struct packed {
        cause_t [NOUT-1:0] cause;
        cause_t [NOUT-1:0] mask;
    } chan_st_t;

    chan_st_t st_d, st_q;
    cause_t   wr_bits;
    cause_t   evt_bits;

    always_comb begin
        wr_bits  = {wdata[ERR_BIT], wdata[DONE_BIT]};
        evt_bits = {err_evt, done_evt};
        st_d     = st_q;
        for (int o = 0; o < NOUT; o++) begin
            if (clr_sel[o]) begin
                st_d.cause[o] = st_q.cause[o] & ~wr_bits;
            end
            // A new event wins over a clear in the same cycle.
            st_d.cause[o] = st_d.cause[o] | evt_bits;
            if (msk_sel[o]) begin
                st_d.mask[o] = wr_bits;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cause = st_q.cause;
    assign mask  = st_q.mask;

    always_comb begin
        for (int o = 0; o < NOUT; o++) begin
            hit[o] = |(st_q.cause[o] & st_q.mask[o]);
        end
    end

endmodule

// File: rtl/irqagg_glb.sv
module irqagg_glb
    import irqagg_pkg::*;
#(
    parameter int GW = 8,
    parameter int DW = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [GW-1:0]             glb_evt,
    input  logic [NOUT-1:0]           clr_sel,
    input  logic [DW-1:0]             wdata,
    output logic [NOUT-1:0][GW-1:0]   glb
);

    typedef struct packed {
        logic [NOUT-1:0][GW-1:0] word;
    } glb_st_t;

    glb_st_t st_d, st_q;
    logic    wipe;

    always_comb begin
        wipe = &wdata;
        st_d = st_q;
        for (int o = 0; o < NOUT; o++) begin
            if (clr_sel[o] && wipe) begin
                st_d.word[o] = '0;
            end
            st_d.word[o] = st_d.word[o] | glb_evt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign glb = st_q.word;

endmodule

// File: rtl/irqagg_run.sv
module irqagg_run #(
    parameter int NCH = 8,
    parameter int DW  = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tx_go,
    input  logic           tx_halt,
    input  logic           rx_go,
    input  logic           rx_halt,
    input  logic [DW-1:0]  wdata,
    output logic [NCH-1:0] run
);

    localparam int NPAIR = NCH / 2;

    typedef struct packed {
        logic [NCH-1:0] run;
    } run_st_t;

    run_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int n = 0; n < NPAIR; n++) begin
            if (tx_go && wdata[n]) begin
                st_d.run[2*n] = 1'b1;
            end
            if (tx_halt && wdata[n]) begin
                st_d.run[2*n] = 1'b0;
            end
            if (rx_go && wdata[n]) begin
                st_d.run[2*n+1] = 1'b1;
            end
            if (rx_halt && wdata[n]) begin
                st_d.run[2*n+1] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run = st_q.run;

endmodule

// File: rtl/irqagg_sum.sv
module irqagg_sum
    import irqagg_pkg::*;
#(
    parameter int NCH = 8,
    parameter int GW  = 8
) (
    input  logic [NCH-1:0][NOUT-1:0]    hit,
    input  logic [NOUT-1:0][GW-1:0]     glb,
    output logic [NOUT-1:0][NCH/2-1:0]  tx_sum,
    output logic [NOUT-1:0][NCH/2-1:0]  rx_sum,
    output logic [NOUT-1:0]             irq
);

    localparam int NPAIR = NCH / 2;

    always_comb begin
        for (int o = 0; o < NOUT; o++) begin
            for (int n = 0; n < NPAIR; n++) begin
                tx_sum[o][n] = hit[2*n][o];
                rx_sum[o][n] = hit[2*n+1][o];
            end
            irq[o] = (|tx_sum[o]) | (|rx_sum[o]) | (|glb[o]);
        end
    end

endmodule

// File: rtl/dma_irq_agg.sv
module dma_irq_agg
    import irqagg_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int GW     = 8,
    parameter int DW     = 32,
    parameter int ADDR_W = $clog2(A_CHAN + NCH * CH_STRIDE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    done_evt,
    input  logic [NCH-1:0]    err_evt,
    input  logic [GW-1:0]     glb_evt,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic [NCH-1:0]    chan_run,
    output logic [NOUT-1:0]   irq_o
);

    localparam int NPAIR = NCH / 2;

    logic                          tx_go, tx_halt, rx_go, rx_halt;
    logic [NOUT-1:0]               glb_clr;
    logic [NCH-1:0][NOUT-1:0]      clr_sel;
    logic [NCH-1:0][NOUT-1:0]      msk_sel;
    cause_t [NCH-1:0][NOUT-1:0]    cause_all;
    cause_t [NCH-1:0][NOUT-1:0]    mask_all;
    logic [NCH-1:0][NOUT-1:0]      hit_all;
    logic [NOUT-1:0][GW-1:0]       glb_all;
    logic [NOUT-1:0][NPAIR-1:0]    tx_sum;
    logic [NOUT-1:0][NPAIR-1:0]    rx_sum;

    // Write decode
    always_comb begin
        tx_go   = bus_we && (bus_addr == ADDR_W'(A_TXGO));
        tx_halt = bus_we && (bus_addr == ADDR_W'(A_TXHALT));
        rx_go   = bus_we && (bus_addr == ADDR_W'(A_RXGO));
        rx_halt = bus_we && (bus_addr == ADDR_W'(A_RXHALT));
        for (int o = 0; o < NOUT; o++) begin
            glb_clr[o] = bus_we && (bus_addr == ADDR_W'(A_GLB + o));
        end
        for (int c = 0; c < NCH; c++) begin
            for (int o = 0; o < NOUT; o++) begin
                clr_sel[c][o] = bus_we &&
                    (bus_addr == ADDR_W'(A_CHAN + c * CH_STRIDE + o));
                msk_sel[c][o] = bus_we &&
                    (bus_addr == ADDR_W'(A_CHAN + c * CH_STRIDE + NOUT + o));
            end
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        irqagg_chan #(
            .DW (DW)
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .done_evt (done_evt[c]),
            .err_evt  (err_evt[c]),
            .clr_sel  (clr_sel[c]),
            .msk_sel  (msk_sel[c]),
            .wdata    (bus_wdata),
            .cause    (cause_all[c]),
            .mask     (mask_all[c]),
            .hit      (hit_all[c])
        );
    end

    irqagg_glb #(
        .GW (GW),
        .DW (DW)
    ) u_glb (
        .clk     (clk),
        .rst_n   (rst_n),
        .glb_evt (glb_evt),
        .clr_sel (glb_clr),
        .wdata   (bus_wdata),
        .glb     (glb_all)
    );

    irqagg_run #(
        .NCH (NCH),
        .DW  (DW)
    ) u_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .tx_go   (tx_go),
        .tx_halt (tx_halt),
        .rx_go   (rx_go),
        .rx_halt (rx_halt),
        .wdata   (bus_wdata),
        .run     (chan_run)
    );

    irqagg_sum #(
        .NCH (NCH),
        .GW  (GW)
    ) u_sum (
        .hit    (hit_all),
        .glb    (glb_all),
        .tx_sum (tx_sum),
        .rx_sum (rx_sum),
        .irq    (irq_o)
    );

    // Read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(A_TXGO) || bus_addr == ADDR_W'(A_TXHALT)) begin
            for (int n = 0; n < NPAIR; n++) begin
                bus_rdata[n] = chan_run[2*n];
            end
        end
        if (bus_addr == ADDR_W'(A_RXGO) || bus_addr == ADDR_W'(A_RXHALT)) begin
            for (int n = 0; n < NPAIR; n++) begin
                bus_rdata[n] = chan_run[2*n+1];
            end
        end
        for (int o = 0; o < NOUT; o++) begin
            if (bus_addr == ADDR_W'(A_TXSUM + o)) begin
                bus_rdata[NPAIR-1:0] = tx_sum[o];
            end
            if (bus_addr == ADDR_W'(A_RXSUM + o)) begin
                bus_rdata[NPAIR-1:0] = rx_sum[o];
            end
            if (bus_addr == ADDR_W'(A_GLB + o)) begin
                bus_rdata[GW-1:0] = glb_all[o];
            end
        end
        for (int c = 0; c < NCH; c++) begin
            for (int o = 0; o < NOUT; o++) begin
                if (bus_addr == ADDR_W'(A_CHAN + c * CH_STRIDE + o)) begin
                    bus_rdata[DONE_BIT] = cause_all[c][o][0];
                    bus_rdata[ERR_BIT]  = cause_all[c][o][1];
                end
                if (bus_addr == ADDR_W'(A_CHAN + c * CH_STRIDE + NOUT + o)) begin
                    bus_rdata[DONE_BIT] = mask_all[c][o][0];
                    bus_rdata[ERR_BIT]  = mask_all[c][o][1];
                end
            end
        end
    end

endmodule

// File: rtl/irqagg_chk.sv
module irqagg_chk
    import irqagg_pkg::*;
#(
    parameter int NCH = 8,
    parameter int GW  = 8
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            bus_we,
    input logic [NCH-1:0]                  done_evt,
    input logic [NCH-1:0]                  err_evt,
    input logic [NCH-1:0][NOUT-1:0][1:0]   cause_all,
    input logic [NCH-1:0][NOUT-1:0][1:0]   mask_all,
    input logic [NOUT-1:0][GW-1:0]         glb_all,
    input logic [NOUT-1:0][NCH/2-1:0]      tx_sum,
    input logic [NOUT-1:0][NCH/2-1:0]      rx_sum,
    input logic [NCH-1:0]                  chan_run,
    input logic [NOUT-1:0]                 irq_o
);

    logic [NCH-1:0] all_done;
    logic [NCH-1:0] all_err;

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            all_done[c] = 1'b1;
            all_err[c]  = 1'b1;
            for (int o = 0; o < NOUT; o++) begin
                all_done[c] = all_done[c] & cause_all[c][o][0];
                all_err[c]  = all_err[c] & cause_all[c][o][1];
            end
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_evt
        assert_done_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
            done_evt[c] |=> all_done[c]);
        // The error event must land even when a clear write hits the same copy.
        assert_evt_beats_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
            err_evt[c] |=> all_err[c]);
    end

    assert_no_silent_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> ((cause_all & $past(cause_all)) == $past(cause_all)));

    assert_mask_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable(mask_all));

    assert_nomask_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_all == '0) |-> (tx_sum == '0 && rx_sum == '0));

    assert_quiet_lines_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_all == '0 && glb_all == '0) |-> (irq_o == '0));

    assert_glb_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> ((glb_all & $past(glb_all)) == $past(glb_all)));

    assert_run_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable(chan_run));

endmodule

bind dma_irq_agg irqagg_chk #(
    .NCH (NCH),
    .GW  (GW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .done_evt  (done_evt),
    .err_evt   (err_evt),
    .cause_all (cause_all),
    .mask_all  (mask_all),
    .glb_all   (glb_all),
    .tx_sum    (tx_sum),
    .rx_sum    (rx_sum),
    .chan_run  (chan_run),
    .irq_o     (irq_o)
);

// File: tb/sim_dma_irq_agg.sv
`timescale 1ns/1ps
module sim_dma_irq_agg;

    localparam int NCH = 8;
    localparam int GW  = 8;
    localparam int DW  = 32;
    localparam int AW  = 7;
    localparam int NO  = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] done_evt = '0;
    logic [NCH-1:0] err_evt = '0;
    logic [GW-1:0]  glb_evt = '0;
    logic           we = 1'b0;
    logic [AW-1:0]  addr = '0;
    logic [DW-1:0]  wdata = '0;
    logic [DW-1:0]  rdata;
    logic [NCH-1:0] run;
    logic [NO-1:0]  irq;

    always #4 clk = ~clk;

    dma_irq_agg #(.NCH(NCH), .GW(GW), .DW(DW)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .done_evt  (done_evt),
        .err_evt   (err_evt),
        .glb_evt   (glb_evt),
        .bus_we    (we),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .chan_run  (run),
        .irq_o     (irq)
    );

    // Reference state
    bit [1:0] m_cause [NCH][NO];
    bit [1:0] m_mask  [NCH][NO];
    bit [GW-1:0] m_glb [NO];
    bit m_run [NCH];

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    function automatic logic [DW-1:0] exp_rd(int a);
        logic [DW-1:0] r = '0;
        bit [1:0] v;
        if (a == 0 || a == 1) begin
            for (int n = 0; n < NCH/2; n++) r[n] = m_run[2*n];
        end else if (a == 2 || a == 3) begin
            for (int n = 0; n < NCH/2; n++) r[n] = m_run[2*n+1];
        end else if (a >= 4 && a < 8) begin
            for (int n = 0; n < NCH/2; n++) r[n] = |(m_cause[2*n][a-4] & m_mask[2*n][a-4]);
        end else if (a >= 8 && a < 12) begin
            for (int n = 0; n < NCH/2; n++) r[n] = |(m_cause[2*n+1][a-8] & m_mask[2*n+1][a-8]);
        end else if (a >= 12 && a < 16) begin
            r[GW-1:0] = m_glb[a-12];
        end else if (a >= 16 && a < 16 + 8*NCH) begin
            int c = (a - 16) / 8;
            int s = (a - 16) % 8;
            v = (s < 4) ? m_cause[c][s] : m_mask[c][s-4];
            r[0] = v[0];
            r[6] = v[1];
        end
        return r;
    endfunction

    function automatic logic [NO-1:0] exp_irq();
        logic [NO-1:0] r = '0;
        for (int o = 0; o < NO; o++) begin
            if (m_glb[o] != 0) r[o] = 1'b1;
            for (int c = 0; c < NCH; c++) begin
                if ((m_cause[c][o] & m_mask[c][o]) != 0) r[o] = 1'b1;
            end
        end
        return r;
    endfunction

    task automatic model_update();
        int a = int'(addr);
        if (we) begin
            if (a < 4) begin
                for (int n = 0; n < NCH/2; n++) begin
                    if (wdata[n]) begin
                        if (a == 0) m_run[2*n] = 1;
                        if (a == 1) m_run[2*n] = 0;
                        if (a == 2) m_run[2*n+1] = 1;
                        if (a == 3) m_run[2*n+1] = 0;
                    end
                end
            end else if (a >= 12 && a < 16) begin
                if (wdata == '1) m_glb[a-12] = '0;
            end else if (a >= 16 && a < 16 + 8*NCH) begin
                int c = (a - 16) / 8;
                int s = (a - 16) % 8;
                if (s < 4) m_cause[c][s] = m_cause[c][s] & ~{wdata[6], wdata[0]};
                else m_mask[c][s-4] = {wdata[6], wdata[0]};
            end
        end
        for (int c = 0; c < NCH; c++) begin
            for (int o = 0; o < NO; o++) begin
                if (done_evt[c]) m_cause[c][o][0] = 1;
                if (err_evt[c])  m_cause[c][o][1] = 1;
            end
        end
        for (int o = 0; o < NO; o++) m_glb[o] = m_glb[o] | glb_evt;
    endtask

    task automatic check(string tag);
        logic [DW-1:0] er = exp_rd(int'(addr));
        logic [NO-1:0] ei = exp_irq();
        logic [NCH-1:0] eu;
        for (int c = 0; c < NCH; c++) eu[c] = m_run[c];
        n_chk++;
        if (rdata !== er) begin
            n_bad++;
            $display("FAIL %s rdata addr=%0d actual=%h expected=%h", tag, addr, rdata, er);
        end
        n_chk++;
        if (irq !== ei) begin
            n_bad++;
            $display("FAIL %s/R7 irq actual=%b expected=%b", tag, irq, ei);
        end
        n_chk++;
        if (run !== eu) begin
            n_bad++;
            $display("FAIL %s/R9 run actual=%b expected=%b", tag, run, eu);
        end
    endtask

    task automatic step(string tag);
        @(posedge clk);
        if (rst_n) model_update();
        @(negedge clk);
        check(tag);
    endtask

    task automatic wr(int a, logic [DW-1:0] d, string tag);
        we = 1'b1;
        addr = AW'(a);
        wdata = d;
        step(tag);
        we = 1'b0;
        wdata = '0;
    endtask

    task automatic rd(int a, string tag);
        addr = AW'(a);
        step(tag);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        rd(16, "R1");
        rd(0, "R1");
        rd(12, "R1");
        rst_n = 1'b1;
        rd(20, "R1");

        // R2: events set both causes in every copy
        done_evt[3] = 1'b1;
        step("R2");
        done_evt = '0;
        for (int o = 0; o < NO; o++) rd(16 + 24 + o, "R2");
        err_evt[4] = 1'b1;
        step("R2");
        err_evt = '0;
        for (int o = 0; o < NO; o++) rd(16 + 32 + o, "R2");

        // R5: masks store bits 0 and 6 only
        wr(16 + 24 + 4 + 1, 32'hFFFF_FFFF, "R5");
        rd(16 + 24 + 4 + 1, "R5");
        // R6: channel 3 is receive pair 1 on line 1
        rd(9, "R6");
        rd(5, "R6");
        wr(16 + 32 + 4 + 2, 32'h0000_0040, "R5");
        rd(6, "R6");
        rd(10, "R6");

        // R3: clear one copy only; zero bits do nothing
        wr(16 + 24 + 1, 32'h0000_0001, "R3");
        for (int o = 0; o < NO; o++) rd(16 + 24 + o, "R3");
        wr(16 + 32 + 2, 32'hFFFF_FFBE, "R3");
        rd(16 + 32 + 2, "R3");
        rd(6, "R3");

        // R4: event and clear in the same cycle
        done_evt[5] = 1'b1;
        wr(16 + 40 + 0, 32'h0000_0041, "R4");
        done_evt = '0;
        rd(16 + 40 + 0, "R4");

        // R8: global words
        glb_evt = 8'h81;
        step("R8");
        glb_evt = '0;
        rd(12, "R8");
        wr(12, 32'h7FFF_FFFF, "R8");
        rd(12, "R8");
        wr(12, 32'hFFFF_FFFF, "R8");
        rd(12, "R8");
        rd(13, "R8");
        glb_evt = 8'h10;
        wr(13, 32'hFFFF_FFFF, "R8");
        glb_evt = '0;
        rd(13, "R8");

        // R9: run control by pair index
        wr(0, 32'h5, "R9");
        rd(0, "R9");
        wr(2, 32'h2, "R9");
        rd(2, "R9");
        wr(1, 32'h4, "R9");
        rd(1, "R9");
        wr(3, 32'h0, "R9");
        rd(3, "R9");

        // R10: unmapped space
        wr(100, 32'hFFFF_FFFF, "R10");
        rd(100, "R10");
        rd(127, "R10");

        // Mixed traffic
        for (int i = 0; i < 600; i++) begin
            done_evt = NCH'($urandom);
            err_evt  = NCH'($urandom) & NCH'($urandom);
            glb_evt  = ($urandom % 8 == 0) ? GW'($urandom) : '0;
            we       = $urandom % 2;
            addr     = AW'($urandom % 96);
            wdata    = ($urandom % 4 == 0) ? '1 : $urandom;
            step("R3_R6_mix");
        end
        done_evt = '0;
        err_evt = '0;
        glb_evt = '0;
        we = 1'b0;
        for (int a = 0; a < 96; a++) rd(a, "R6_R5_sweep");

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule